// File: doc/BRIEF.md
# Dual-Mode Card Clock Divider

This block derives the bus clock for a memory-card host from a faster system clock. It runs a counter on the system clock and produces a card clock whose period is a whole number of system cycles. A static mode input selects between two ratio rules. The even-only rule divides by twice the divider value plus two. The extended rule adds an odd-ratio bit, so every ratio from 2 to 513 is available. Along with the clock, the block gives a one-cycle pulse in the first system cycle of every card-clock high phase.

A small wait counter sits beside the divider. It is loaded with a number of card clocks and counts down on each rising-edge pulse. It then shows a done flag. The host uses it to hold off the next card command for a minimum number of card clock periods, for example the eight clocks needed after a mode-switch command.

The divider setting is taken only when a new card-clock period begins. A change of setting therefore never shortens or stretches the period already in progress. Dropping the enable parks the clock low at once.

Top module: `cclk_gen`

## Requirements
- R1: While reset is asserted, card_clk and rise_pulse are 0 and wait_done is 1.
- R2: With ext_mode = 0 the card-clock period is 2·(div_val+1) system cycles, high for div_val+1 cycles and low for div_val+1 cycles; odd_bit is ignored.
- R3: With ext_mode = 1 the period is 2·div_val + odd_bit + 2 system cycles, high for div_val+1 cycles and low for the rest.
- R4: The extreme settings work: div_val = 0 gives a 2-cycle period, div_val = 255 with odd_bit = 1 in extended mode gives 513 cycles, and div_val = 255 in even-only mode gives 512 cycles.
- R5: ext_mode, div_val and odd_bit are sampled only on the system edge that starts a card-clock period. A change during a period affects only the following period.
- R6: When en is sampled 0, card_clk and rise_pulse are 0 from the next cycle on. When en is sampled 1 after being 0, card_clk goes high on that edge and a full new period begins.
- R7: rise_pulse is 1 for exactly one cycle, the first cycle of each card-clock high phase, and at no other time.
- R8: When wait_load is sampled 1, the counter takes wait_cycles. Load has priority over a decrement in the same cycle. The counter then drops by one after each cycle in which rise_pulse is 1. wait_done is 1 exactly when the counter is 0, so a load of 0 gives done on the next cycle.
- R9: Once wait_done is 1 it stays 1 until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run the card clock; 0 parks it low |
| ext_mode | input | 1 | 0: even-only ratio rule, 1: extended ratio rule with odd bit |
| div_val | input | DIV_W (8) | Divider value |
| odd_bit | input | 1 | Adds one system cycle to the low phase in extended mode |
| wait_load | input | 1 | Load the wait counter |
| wait_cycles | input | WAIT_W (8) | Number of card clocks to wait |
| card_clk | output | 1 | Divided card clock |
| rise_pulse | output | 1 | One-cycle pulse at each card-clock rising edge |
| wait_done | output | 1 | Wait counter has reached zero |

## Verification
The assertions assume that the inputs change only between system clock edges and that reset holds long enough to clear the registers. They assume nothing about when settings change relative to a card-clock period. The stimulus therefore drives all inputs on the falling system edge. It changes the divider, the mode, the enable and the wait load at arbitrary points of a period, including the cycle in which a pulse coincides with a load. In this way the sampling rule and the load priority are both exercised.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
    typedef enum logic {
        MODE_EVEN = 1'b0,
        MODE_EXT  = 1'b1
    } div_mode_e;
endpackage

// File: rtl/cclk_ratio.sv
module cclk_ratio
    import cclk_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int RATIO_W = DIV_W + 2
) (
    input  logic               ext_mode,
    input  logic [DIV_W-1:0]   div_val,
    input  logic               odd_bit,
    output logic [RATIO_W-1:0] ratio,
    output logic [RATIO_W-1:0] high_len
);
    logic odd_eff;

    always_comb begin
        odd_eff  = (div_mode_e'(ext_mode) == MODE_EXT) ? odd_bit : 1'b0;
        high_len = RATIO_W'(div_val) + RATIO_W'(1);
        ratio    = RATIO_W'({div_val, 1'b0}) + RATIO_W'(2) + RATIO_W'(odd_eff);
    end
endmodule

// File: rtl/cclk_phase.sv
module cclk_phase #(
    parameter int RATIO_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic [RATIO_W-1:0] high_in,
    output logic               card_clk,
    output logic               rise
);
    typedef struct packed {
        logic               run;
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] ratio;
        logic [RATIO_W-1:0] high;
        logic               level;
        logic               rise;
    } phase_t;

    phase_t st_q, st_d;
    logic [RATIO_W-1:0] cnt_inc;
    logic               period_end;

    always_comb begin
        st_d       = st_q;
        cnt_inc    = st_q.cnt + RATIO_W'(1);
        period_end = (st_q.cnt == st_q.ratio - RATIO_W'(1));
        if (!en) begin
            st_d.run   = 1'b0;
            st_d.cnt   = '0;
            st_d.level = 1'b0;
            st_d.rise  = 1'b0;
        end else if (!st_q.run || period_end) begin
            st_d.run   = 1'b1;
            st_d.cnt   = '0;
            st_d.ratio = ratio_in;
            st_d.high  = high_in;
            st_d.level = 1'b1;
            st_d.rise  = 1'b1;
        end else begin
            st_d.cnt   = cnt_inc;
            st_d.level = (cnt_inc < st_q.high);
            st_d.rise  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign card_clk = st_q.level;
    assign rise     = st_q.rise;
endmodule

// File: rtl/cclk_wait.sv
module cclk_wait #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [WAIT_W-1:0] count,
    output logic              done
);
    typedef struct packed {
        logic [WAIT_W-1:0] left;
    } wait_t;

    wait_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.left = count;
        end else if (tick && (st_q.left != '0)) begin
            st_d.left = st_q.left - WAIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = (st_q.left == '0);
endmodule

// File: rtl/cclk_gen.sv
module cclk_gen #(
    parameter int DIV_W  = 8,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ext_mode,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              odd_bit,
    input  logic              wait_load,
    input  logic [WAIT_W-1:0] wait_cycles,
    output logic              card_clk,
    output logic              rise_pulse,
    output logic              wait_done
);
    localparam int RATIO_W = DIV_W + 2;

    logic [RATIO_W-1:0] ratio_w;
    logic [RATIO_W-1:0] high_w;

    cclk_ratio #(.DIV_W(DIV_W), .RATIO_W(RATIO_W)) u_ratio (
        .ext_mode (ext_mode),
        .div_val  (div_val),
        .odd_bit  (odd_bit),
        .ratio    (ratio_w),
        .high_len (high_w)
    );

    cclk_phase #(.RATIO_W(RATIO_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .ratio_in (ratio_w),
        .high_in  (high_w),
        .card_clk (card_clk),
        .rise     (rise_pulse)
    );

    cclk_wait #(.WAIT_W(WAIT_W)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (rise_pulse),
        .load  (wait_load),
        .count (wait_cycles),
        .done  (wait_done)
    );
endmodule

// File: rtl/cclk_gen_chk.sv
module cclk_gen_chk #(
    parameter int DIV_W  = 8,
    parameter int WAIT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              ext_mode,
    input logic [DIV_W-1:0]  div_val,
    input logic              odd_bit,
    input logic              wait_load,
    input logic [WAIT_W-1:0] wait_cycles,
    input logic              card_clk,
    input logic              rise_pulse,
    input logic              wait_done
);
    logic unused_ok;
    assign unused_ok = ^{ext_mode, div_val, odd_bit};

    p_pulse_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |-> card_clk);

    p_rise_flagged_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> rise_pulse);

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

    p_parked_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!card_clk && !rise_pulse));

    p_start_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !$past(en)) |=> (card_clk && rise_pulse));

    p_load_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_load && wait_cycles != '0) |=> !wait_done);

    p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_done && !wait_load) |=> wait_done);
endmodule

bind cclk_gen cclk_gen_chk #(.DIV_W(DIV_W), .WAIT_W(WAIT_W)) u_chk (.*);

// File: tb/cclk_gen_bench.sv
module cclk_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       ext_mode = 1'b0;
    logic [7:0] div_val = '0;
    logic       odd_bit = 1'b0;
    logic       wait_load = 1'b0;
    logic [7:0] wait_cycles = '0;
    logic       card_clk;
    logic       rise_pulse;
    logic       wait_done;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    cclk_gen u_cclk_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .ext_mode(ext_mode),
        .div_val(div_val), .odd_bit(odd_bit), .wait_load(wait_load),
        .wait_cycles(wait_cycles), .card_clk(card_clk),
        .rise_pulse(rise_pulse), .wait_done(wait_done)
    );

    // Reference model: queue of upcoming card-clock levels (2 = first high, 1 = high, 0 = low)
    int q[$];
    int exp_clk = 0;
    int exp_rise = 0;
    int exp_left = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            exp_clk = 0;
            exp_rise = 0;
            exp_left = 0;
        end else begin
            if (wait_load) exp_left = int'(wait_cycles);
            else if (exp_rise == 1 && exp_left > 0) exp_left = exp_left - 1;
            if (!en) begin
                q.delete();
                exp_clk = 0;
                exp_rise = 0;
            end else begin
                if (q.size() == 0) begin
                    int per;
                    int hi;
                    per = ext_mode ? 2 * int'(div_val) + int'(odd_bit) + 2
                                   : 2 * (int'(div_val) + 1);
                    hi = per / 2;
                    for (int k = 0; k < per; k++)
                        q.push_back(k == 0 ? 2 : (k < hi ? 1 : 0));
                end
                exp_clk = (q[0] != 0) ? 1 : 0;
                exp_rise = (q[0] == 2) ? 1 : 0;
                void'(q.pop_front());
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, "card_clk", int'(card_clk), exp_clk);
            check(cur_req, "rise_pulse", int'(rise_pulse), exp_rise);
            check(cur_req, "wait_done", int'(wait_done), (exp_left == 0) ? 1 : 0);
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_div(logic m, int d, logic o);
        ext_mode = m;
        div_val = 8'(d);
        odd_bit = o;
    endtask

    task automatic measure(output int hi, output int lo);
        do @(negedge clk); while (!rise_pulse);
        hi = 0;
        while (card_clk) begin hi++; @(negedge clk); end
        lo = 0;
        while (!card_clk) begin lo++; @(negedge clk); end
    endtask

    initial begin
        int hi, lo, n;
        @(negedge clk);
        cycles(3);
        check("R1", "reset card_clk", int'(card_clk), 0);
        check("R1", "reset rise_pulse", int'(rise_pulse), 0);
        check("R1", "reset wait_done", int'(wait_done), 1);
        rst_n = 1'b1;
        cur_req = "R6";
        cycles(4);

        cur_req = "R2";
        set_div(1'b0, 3, 1'b1);
        en = 1'b1;
        measure(hi, lo);
        check("R2", "even high", hi, 4);
        check("R2", "even low (odd_bit ignored)", lo, 4);

        cur_req = "R3";
        set_div(1'b1, 3, 1'b1);
        measure(hi, lo); measure(hi, lo);
        check("R3", "ext high", hi, 4);
        check("R3", "ext low", lo, 5);
        set_div(1'b1, 0, 1'b1);
        measure(hi, lo); measure(hi, lo);
        check("R3", "ext ratio3 high", hi, 1);
        check("R3", "ext ratio3 low", lo, 2);

        cur_req = "R4";
        set_div(1'b0, 0, 1'b1);
        measure(hi, lo); measure(hi, lo);
        check("R4", "ratio2 high", hi, 1);
        check("R4", "ratio2 low", lo, 1);
        set_div(1'b1, 255, 1'b1);
        measure(hi, lo); measure(hi, lo);
        check("R4", "ratio513 high", hi, 256);
        check("R4", "ratio513 low", lo, 257);
        set_div(1'b0, 255, 1'b1);
        measure(hi, lo); measure(hi, lo);
        check("R4", "ratio512 high", hi, 256);
        check("R4", "ratio512 low", lo, 256);

        cur_req = "R6";
        set_div(1'b1, 5, 1'b0);
        cycles(5);
        en = 1'b0;
        cycles(2);
        check("R6", "parked card_clk", int'(card_clk), 0);
        en = 1'b1;
        cycles(1);
        check("R6", "restart high", int'(card_clk), 1);
        check("R6", "restart pulse", int'(rise_pulse), 1);

        cur_req = "R8";
        set_div(1'b0, 1, 1'b0);
        wait_load = 1'b1; wait_cycles = 8'd8;
        cycles(1);
        wait_load = 1'b0;
        n = 0;
        while (!wait_done) begin
            if (rise_pulse) n++;
            @(negedge clk);
        end
        check("R8", "pulses until done", n, 8);
        wait_load = 1'b1; wait_cycles = 8'd0;
        cycles(1);
        wait_load = 1'b0;
        check("R8", "load zero done", int'(wait_done), 1);

        cur_req = "R9";
        cycles(30);
        check("R9", "done held", int'(wait_done), 1);

        cur_req = "R5";
        for (int it = 0; it < 600; it++) begin
            set_div(1'($urandom_range(0, 1)), int'($urandom_range(0, 6)),
                    1'($urandom_range(0, 1)));
            en = ($urandom_range(0, 19) != 0);
            wait_load = ($urandom_range(0, 9) == 0);
            wait_cycles = 8'($urandom_range(0, 5));
            cycles(int'($urandom_range(1, 6)));
        end
        wait_load = 1'b0;
        cycles(20);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule